// File: doc/BRIEF.md
# Interlaced Field Alternation Sequencer

This block sits beside a vertical timing engine that can only produce progressive frames and lets it drive an interlaced display. A host issues a setup command carrying the full-frame vertical timing (visible rows, total rows, sync start and sync end), the sync polarity and an interlace select. The block turns that frame timing into the values the engine is programmed with. For progressive operation these are plain frame values. For interlaced operation they are per-field values, and the vertical sync generated by the engine is repurposed.

In interlaced operation the engine raises a line-match strobe once per field, partway through the frame. On each strobe the block flips a lower-field flag. It also lengthens or restores the vertical front porch by one line and re-issues the fetch base address, offset by one line stride for the lower field. The fetch stride is doubled, so each field reads every other line of the frame buffer. Host address updates may arrive at any time, including in the same cycle as a strobe.

Top module: `ilace_field_seq`

## Requirements
- R1: In progressive mode the outputs are the frame timing in minus-one form, taken modulo 2^ROW_W: `vis_m1_o`=visible-1, `sync_m1_o`=sync_end-sync_start-1, `bp_m1_o`=total-sync_start-1 and `fp_m1_o`=sync_start-visible-1. The enables are `vbp_en_o`=(total!=sync_start), `vfp_en_o`=(sync_start!=visible) and `vsync_en_o`=(sync_end!=sync_start). `vsync_pol_o` equals the captured `vs_neg_i`.
- R2: In interlaced mode, with field_total = total>>1 and field_visible = visible>>1, `vis_m1_o`=field_visible-1 and `sync_m1_o`=field_total-2. `vsync_pol_o`=0 and `vfp_en_o`=`vsync_en_o`=1.
- R3: In interlaced mode the base front porch fp0 is (sync_start-visible-2)>>1 when sync_start >= visible+4, and 1 otherwise. With the flag clear, `fp_m1_o`=fp0-1.
- R4: In interlaced mode the back porch is bp = max(0, field_total-field_visible-fp0), `bp_m1_o`=bp-1 modulo 2^ROW_W, and `vbp_en_o`=(bp>0).
- R5: In interlaced mode a host update drives `stride_o`=2*stride. `base_addr_o` is the address plus one stride when the (new) lower-field flag is 1, and the address alone otherwise. `addr_wr_o` pulses for one cycle.
- R6: In interlaced mode each `line_match_i` toggles `lower_field_o` one cycle later, and `fp_m1_o` becomes fp0-1+`lower_field_o`.
- R7: `match_en_o` is 1 exactly when the captured mode is interlaced. `match_line_o` is the constant MATCH_LINE (default 32).
- R8: On a toggle with no host update, the saved address is re-issued (plus the saved stride when the new flag is 1, with a one-cycle `addr_wr_o` pulse) only if the saved address is nonzero. With no update and no toggle, `addr_wr_o` stays 0.
- R9: `stop_i` clears the saved address, so later toggles issue nothing and `base_addr_o` holds. The flag keeps toggling.
- R10: A host update coinciding with a toggle is applied first and then offset by the toggled flag.
- R11: `setup_i` clears the lower-field flag and the saved address, and produces no address write.
- R12: In progressive mode `line_match_i` is ignored (flag stays 0). A host update issues the address unchanged, with `stride_o` equal to the stride.
- R13: After reset `lower_field_o`, `base_addr_o`, `stride_o`, `addr_wr_o` and `match_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| setup_i | input | 1 | Capture timing and mode; restart the field sequence |
| ilace_i | input | 1 | Interlace select, captured on setup |
| vs_neg_i | input | 1 | Progressive sync polarity, captured on setup |
| vis_rows_i | input | ROW_W | Frame visible rows |
| tot_rows_i | input | ROW_W | Frame total rows |
| vs_start_i | input | ROW_W | Frame row where vertical sync starts |
| vs_end_i | input | ROW_W | Frame row where vertical sync ends |
| stop_i | input | 1 | Stop request; forgets the saved address |
| upd_i | input | 1 | Host base address / stride update |
| addr_i | input | ADDR_W | Frame base address |
| stride_i | input | STRIDE_W | Frame line stride |
| line_match_i | input | 1 | Mid-frame line-match strobe from the engine |
| vis_m1_o | output | ROW_W | Visible rows minus one |
| sync_m1_o | output | ROW_W | Sync-width rows minus one |
| bp_m1_o | output | ROW_W | Back-porch rows minus one |
| fp_m1_o | output | ROW_W | Front-porch rows minus one |
| vbp_en_o | output | 1 | Back-porch enable |
| vfp_en_o | output | 1 | Front-porch enable |
| vsync_en_o | output | 1 | Vertical sync enable |
| vsync_pol_o | output | 1 | Vertical sync polarity |
| match_en_o | output | 1 | Line-match event enable |
| match_line_o | output | ROW_W | Line-match row |
| lower_field_o | output | 1 | Lower-field flag |
| base_addr_o | output | ADDR_W | Effective fetch base address |
| stride_o | output | STRIDE_W+1 | Effective fetch stride |
| addr_wr_o | output | 1 | One-cycle pulse when base address/stride are issued |

## Verification
The assertions assume the frame timing is ordered (visible <= sync_start <= sync_end <= total), that the interlaced frame total is odd, and that setup is never asserted together with a line-match strobe that is meant to toggle. The bench builds every configuration from non-negative gaps added to the visible count and bumps the total to an odd value for interlaced cases. Its address scenarios drive setup, stop, update and strobe only in combinations whose outcome the priority rules define.

// File: rtl/ilace_seq_pkg.sv
package ilace_seq_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_HOST  = 2'd1,
    SRC_SAVED = 2'd2,
    SRC_CLEAR = 2'd3
  } addr_src_e;
endpackage

// File: rtl/ilace_cfg_reg.sv
module ilace_cfg_reg #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_i,
  input  logic             ilace_i,
  input  logic             vs_neg_i,
  input  logic [ROW_W-1:0] vis_i,
  input  logic [ROW_W-1:0] tot_i,
  input  logic [ROW_W-1:0] vss_i,
  input  logic [ROW_W-1:0] vse_i,
  output logic             ilace_o,
  output logic             vs_neg_o,
  output logic [ROW_W-1:0] vis_o,
  output logic [ROW_W-1:0] tot_o,
  output logic [ROW_W-1:0] vss_o,
  output logic [ROW_W-1:0] vse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilace_o  <= 1'b0;
      vs_neg_o <= 1'b0;
      vis_o    <= '0;
      tot_o    <= '0;
      vss_o    <= '0;
      vse_o    <= '0;
    end else if (setup_i) begin
      ilace_o  <= ilace_i;
      vs_neg_o <= vs_neg_i;
      vis_o    <= vis_i;
      tot_o    <= tot_i;
      vss_o    <= vss_i;
      vse_o    <= vse_i;
    end
  end
endmodule

// File: rtl/ilace_timing_calc.sv
module ilace_timing_calc #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             ilace_i,
  input  logic             vs_neg_i,
  input  logic             lower_i,
  input  logic [ROW_W-1:0] vis_i,
  input  logic [ROW_W-1:0] tot_i,
  input  logic [ROW_W-1:0] vss_i,
  input  logic [ROW_W-1:0] vse_i,
  output logic [ROW_W-1:0] vis_m1_o,
  output logic [ROW_W-1:0] sync_m1_o,
  output logic [ROW_W-1:0] bp_m1_o,
  output logic [ROW_W-1:0] fp_m1_o,
  output logic             vbp_en_o,
  output logic             vfp_en_o,
  output logic             vsync_en_o,
  output logic             vsync_pol_o
);
  localparam int unsigned EW = ROW_W + 2;
  typedef logic signed [EW-1:0] ext_t;
  localparam ext_t K0 = ext_t'(0);
  localparam ext_t K1 = ext_t'(1);
  localparam ext_t K2 = ext_t'(2);
  localparam ext_t K4 = ext_t'(4);
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  ext_t vis_x, tot_x, vss_x;
  ext_t vact, vtot0, fp0, vbp;

  // per-field arithmetic in a widened signed domain
  always_comb begin
    vis_x = ext_t'(vis_i);
    tot_x = ext_t'(tot_i);
    vss_x = ext_t'(vss_i);
    vact  = vis_x >>> 1;
    vtot0 = tot_x >>> 1;
    fp0   = (vss_x >= vis_x + K4) ? ((vss_x - vis_x - K2) >>> 1) : K1;
    vbp   = vtot0 - vact - fp0;
    if (vbp < K0) vbp = K0;
  end

  always_comb begin
    if (ilace_i) begin
      vis_m1_o    = ROW_W'(vact - K1);
      sync_m1_o   = ROW_W'(vtot0 - K2);
      bp_m1_o     = ROW_W'(vbp - K1);
      fp_m1_o     = ROW_W'(fp0 - K1 + ext_t'(lower_i));
      vbp_en_o    = vbp > K0;
      vfp_en_o    = 1'b1;
      vsync_en_o  = 1'b1;
      vsync_pol_o = 1'b0;
    end else begin
      vis_m1_o    = vis_i - ONE;
      sync_m1_o   = vse_i - vss_i - ONE;
      bp_m1_o     = tot_i - vss_i - ONE;
      fp_m1_o     = vss_i - vis_i - ONE;
      vbp_en_o    = tot_i != vss_i;
      vfp_en_o    = vss_i != vis_i;
      vsync_en_o  = vse_i != vss_i;
      vsync_pol_o = vs_neg_i;
    end
  end
endmodule

// File: rtl/ilace_field_ctrl.sv
module ilace_field_ctrl
  import ilace_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STRIDE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                setup_i,
  input  logic                stop_i,
  input  logic                ilace_i,
  input  logic                upd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                match_i,
  output logic                lower_o,
  output logic [ADDR_W-1:0]   base_addr_o,
  output logic [STRIDE_W:0]   stride_o,
  output logic                addr_wr_o
);
  logic                toggle, lower_n;
  logic [ADDR_W-1:0]   saved_addr;
  logic [STRIDE_W-1:0] saved_stride;
  addr_src_e           src;

  assign toggle  = match_i && ilace_i && !setup_i;
  assign lower_n = setup_i ? 1'b0 : (lower_o ^ toggle);

  // setup > stop > host update > saved re-issue
  always_comb begin
    if (setup_i || stop_i)                 src = SRC_CLEAR;
    else if (upd_i)                        src = SRC_HOST;
    else if (toggle && saved_addr != '0)   src = SRC_SAVED;
    else                                   src = SRC_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lower_o      <= 1'b0;
      saved_addr   <= '0;
      saved_stride <= '0;
      base_addr_o  <= '0;
      stride_o     <= '0;
      addr_wr_o    <= 1'b0;
    end else begin
      lower_o   <= lower_n;
      addr_wr_o <= 1'b0;
      case (src)
        SRC_CLEAR: saved_addr <= '0;
        SRC_HOST: begin
          saved_addr   <= addr_i;
          saved_stride <= stride_i;
          base_addr_o  <= (ilace_i && lower_n) ? addr_i + ADDR_W'(stride_i) : addr_i;
          stride_o     <= ilace_i ? {stride_i, 1'b0} : {1'b0, stride_i};
          addr_wr_o    <= 1'b1;
        end
        SRC_SAVED: begin
          base_addr_o <= lower_n ? saved_addr + ADDR_W'(saved_stride) : saved_addr;
          addr_wr_o   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6
  flag_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && ilace_i && !setup_i) |=> (lower_o != $past(lower_o)));
  // R12
  prog_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ilace_i && !setup_i) |=> $stable(lower_o));
  // R11
  setup_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> (!lower_o && !addr_wr_o));
  // R8
  no_spurious_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !match_i) |=> !addr_wr_o);
  // R9
  stop_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !addr_wr_o);
  // R5
  stride_dbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && ilace_i && !setup_i && !stop_i) |=> (stride_o == {$past(stride_i), 1'b0}));
endmodule

// File: rtl/ilace_field_seq.sv
module ilace_field_seq #(
  parameter int unsigned ROW_W      = 12,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned STRIDE_W   = 16,
  parameter int unsigned MATCH_LINE = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                setup_i,
  input  logic                ilace_i,
  input  logic                vs_neg_i,
  input  logic [ROW_W-1:0]    vis_rows_i,
  input  logic [ROW_W-1:0]    tot_rows_i,
  input  logic [ROW_W-1:0]    vs_start_i,
  input  logic [ROW_W-1:0]    vs_end_i,
  input  logic                stop_i,
  input  logic                upd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                line_match_i,
  output logic [ROW_W-1:0]    vis_m1_o,
  output logic [ROW_W-1:0]    sync_m1_o,
  output logic [ROW_W-1:0]    bp_m1_o,
  output logic [ROW_W-1:0]    fp_m1_o,
  output logic                vbp_en_o,
  output logic                vfp_en_o,
  output logic                vsync_en_o,
  output logic                vsync_pol_o,
  output logic                match_en_o,
  output logic [ROW_W-1:0]    match_line_o,
  output logic                lower_field_o,
  output logic [ADDR_W-1:0]   base_addr_o,
  output logic [STRIDE_W:0]   stride_o,
  output logic                addr_wr_o
);
  logic             cfg_ilace, cfg_neg;
  logic [ROW_W-1:0] cfg_vis, cfg_tot, cfg_vss, cfg_vse;

  ilace_cfg_reg #(.ROW_W(ROW_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .setup_i  (setup_i),
    .ilace_i  (ilace_i),
    .vs_neg_i (vs_neg_i),
    .vis_i    (vis_rows_i),
    .tot_i    (tot_rows_i),
    .vss_i    (vs_start_i),
    .vse_i    (vs_end_i),
    .ilace_o  (cfg_ilace),
    .vs_neg_o (cfg_neg),
    .vis_o    (cfg_vis),
    .tot_o    (cfg_tot),
    .vss_o    (cfg_vss),
    .vse_o    (cfg_vse)
  );

  ilace_field_ctrl #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .setup_i     (setup_i),
    .stop_i      (stop_i),
    .ilace_i     (cfg_ilace),
    .upd_i       (upd_i),
    .addr_i      (addr_i),
    .stride_i    (stride_i),
    .match_i     (line_match_i),
    .lower_o     (lower_field_o),
    .base_addr_o (base_addr_o),
    .stride_o    (stride_o),
    .addr_wr_o   (addr_wr_o)
  );

  ilace_timing_calc #(.ROW_W(ROW_W)) u_calc (
    .ilace_i     (cfg_ilace),
    .vs_neg_i    (cfg_neg),
    .lower_i     (lower_field_o),
    .vis_i       (cfg_vis),
    .tot_i       (cfg_tot),
    .vss_i       (cfg_vss),
    .vse_i       (cfg_vse),
    .vis_m1_o    (vis_m1_o),
    .sync_m1_o   (sync_m1_o),
    .bp_m1_o     (bp_m1_o),
    .fp_m1_o     (fp_m1_o),
    .vbp_en_o    (vbp_en_o),
    .vfp_en_o    (vfp_en_o),
    .vsync_en_o  (vsync_en_o),
    .vsync_pol_o (vsync_pol_o)
  );

  assign match_en_o   = cfg_ilace;
  assign match_line_o = ROW_W'(MATCH_LINE);

  // R2
  ilace_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ilace |-> (vfp_en_o && vsync_en_o && !vsync_pol_o));
  // R6
  fp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lower_field_o) && cfg_ilace) |-> (fp_m1_o == $past(fp_m1_o) + ROW_W'(1)));
endmodule

// File: tb/ilace_field_seq_tb_top.sv
module ilace_field_seq_tb_top;
  localparam int ROW_W = 12, ADDR_W = 32, STRIDE_W = 16;
  localparam int MASK = (1 << ROW_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic setup_i = 0, ilace_i = 0, vs_neg_i = 0, stop_i = 0, upd_i = 0, line_match_i = 0;
  logic [ROW_W-1:0] vis_rows_i = '0, tot_rows_i = '0, vs_start_i = '0, vs_end_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [STRIDE_W-1:0] stride_i = '0;
  logic [ROW_W-1:0] vis_m1_o, sync_m1_o, bp_m1_o, fp_m1_o, match_line_o;
  logic vbp_en_o, vfp_en_o, vsync_en_o, vsync_pol_o, match_en_o, lower_field_o, addr_wr_o;
  logic [ADDR_W-1:0] base_addr_o;
  logic [STRIDE_W:0] stride_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  ilace_field_seq dut_i (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic do_setup(bit il, bit neg, int vis, int tot, int ss, int se);
    setup_i = 1; ilace_i = il; vs_neg_i = neg;
    vis_rows_i = ROW_W'(vis); tot_rows_i = ROW_W'(tot);
    vs_start_i = ROW_W'(ss); vs_end_i = ROW_W'(se);
    tick();
    setup_i = 0;
  endtask

  task automatic pulse(bit m, bit u, bit s, int a, int st);
    line_match_i = m; upd_i = u; stop_i = s;
    addr_i = ADDR_W'(a); stride_i = STRIDE_W'(st);
    tick();
    line_match_i = 0; upd_i = 0; stop_i = 0;
  endtask

  task automatic sweep_one(bit il, bit neg, int vis, int tot, int ss, int se);
    int vact, vt0, fp0, vbp;
    do_setup(il, neg, vis, tot, ss, se);
    chk("R11 flag after setup", lower_field_o, 0);
    chk("R7 match_en", match_en_o, il);
    if (!il) begin
      chk("R1 vis_m1", vis_m1_o, (vis - 1) & MASK);
      chk("R1 sync_m1", sync_m1_o, (se - ss - 1) & MASK);
      chk("R1 bp_m1", bp_m1_o, (tot - ss - 1) & MASK);
      chk("R1 fp_m1", fp_m1_o, (ss - vis - 1) & MASK);
      chk("R1 enables/pol", {vbp_en_o, vfp_en_o, vsync_en_o, vsync_pol_o},
          {tot != ss, ss != vis, se != ss, neg});
      pulse(1, 0, 0, 0, 0);
      chk("R12 match ignored flag", lower_field_o, 0);
      chk("R12 match ignored fp", fp_m1_o, (ss - vis - 1) & MASK);
    end else begin
      vact = vis / 2; vt0 = tot / 2;
      fp0 = (ss >= vis + 4) ? (ss - vis - 2) / 2 : 1;
      vbp = vt0 - vact - fp0;
      if (vbp < 0) vbp = 0;
      chk("R2 vis_m1", vis_m1_o, (vact - 1) & MASK);
      chk("R2 sync_m1", sync_m1_o, (vt0 - 2) & MASK);
      chk("R2 ctl", {vfp_en_o, vsync_en_o, vsync_pol_o}, 3'b110);
      chk("R3 fp_m1 upper", fp_m1_o, (fp0 - 1) & MASK);
      chk("R4 bp_m1", bp_m1_o, (vbp - 1) & MASK);
      chk("R4 bp_en", vbp_en_o, vbp > 0);
      pulse(1, 0, 0, 0, 0);
      chk("R6 flag set", lower_field_o, 1);
      chk("R6 fp_m1 lower", fp_m1_o, fp0 & MASK);
      pulse(1, 0, 0, 0, 0);
      chk("R6 flag clear", lower_field_o, 0);
      chk("R6 fp_m1 back", fp_m1_o, (fp0 - 1) & MASK);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int vlist[5] = '{2, 4, 5, 8, 11};
    #25 rst_ni = 1;
    #2;
    // R13
    chk("R13 reset flag", lower_field_o, 0);
    chk("R13 reset base", base_addr_o, 0);
    chk("R13 reset stride", stride_o, 0);
    chk("R13 reset wr", addr_wr_o, 0);
    chk("R13 reset match_en", match_en_o, 0);
    chk("R7 match line", match_line_o, 32);

    for (int il = 0; il < 2; il++)
      for (int vi = 0; vi < 5; vi++)
        for (int fg = 0; fg < 7; fg++)
          for (int sw = 0; sw < 4; sw++)
            for (int bg = 0; bg < 5; bg++) begin
              int vis = vlist[vi];
              int ss = vis + fg;
              int se = ss + sw;
              int tot = se + bg;
              if (il == 1 && (tot % 2) == 0) tot++;
              sweep_one(il[0], fg[0] ^ bg[0], vis, tot, ss, se);
            end

    // address sequencing, interlaced
    do_setup(1, 0, 480, 525, 490, 496);
    pulse(1, 0, 0, 0, 0);
    chk("R8 no saved addr flag", lower_field_o, 1);
    chk("R8 no saved addr wr", addr_wr_o, 0);
    pulse(0, 1, 0, 'h1000, 'h40);
    chk("R5 lower base", base_addr_o, 'h1040);
    chk("R5 stride doubled", stride_o, 'h80);
    chk("R5 wr pulse", addr_wr_o, 1);
    tick();
    chk("R5 wr one cycle", addr_wr_o, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R8 reissue upper", base_addr_o, 'h1000);
    chk("R8 reissue wr", addr_wr_o, 1);
    pulse(1, 0, 0, 0, 0);
    chk("R8 reissue lower", base_addr_o, 'h1040);
    pulse(1, 1, 0, 'h2000, 'h20);
    chk("R10 upd+toggle to upper", base_addr_o, 'h2000);
    chk("R10 flag", lower_field_o, 0);
    pulse(1, 1, 0, 'h3000, 'h10);
    chk("R10 upd+toggle to lower", base_addr_o, 'h3010);
    chk("R10 stride", stride_o, 'h20);
    pulse(0, 0, 1, 0, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R9 flag still toggles", lower_field_o, 0);
    chk("R9 no reissue", addr_wr_o, 0);
    chk("R9 base held", base_addr_o, 'h3010);
    pulse(0, 1, 0, 'h4000, 'h8);
    do_setup(1, 0, 480, 525, 490, 496);
    chk("R11 setup no wr", addr_wr_o, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R11 saved cleared", addr_wr_o, 0);
    chk("R11 base held", base_addr_o, 'h4000);

    // progressive addressing
    do_setup(0, 1, 480, 525, 490, 492);
    chk("R7 match_en prog", match_en_o, 0);
    pulse(0, 1, 0, 'h5000, 'h30);
    chk("R12 prog base", base_addr_o, 'h5000);
    chk("R12 prog stride", stride_o, 'h30);
    pulse(1, 0, 0, 0, 0);
    chk("R12 prog match flag", lower_field_o, 0);
    chk("R12 prog match wr", addr_wr_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule